// File: doc/BRIEF.md
# Two-Wire Serial Shift Unit

This block is a small shift-register peripheral for a two-wire bus of the open-drain clock-and-data kind. Software programs it through a narrow register port with three registers: control, status and data. The bus clock input advances a 4-bit edge counter on both of its edges. The data line is shifted into an 8-bit register on every clock rising edge. When the counter wraps from 15 to 0, a full byte has passed. A start or stop condition on the bus is recognised by a detector. That detector checks, one cycle after the data edge, that the clock line is still high.

Firmware usually works as follows. It waits for a start, clears the counter, and reads the address byte when the counter overflows. To send or sample a single acknowledge bit, it preloads the counter to 14. In hold mode the block pulls the clock line low after a start or an overflow. The clock stays low until software clears the matching flag, which gives the firmware time to respond.

Top module: `tw_shifter`

## Requirements
- R1: After reset, every register reads 0, and the data pull, clock hold and both interrupt outputs are low.
- R2: In two-wire mode (control bits 5:4 = 2 or 3) with bus clocking enabled (control bit 3), each clock rising edge shifts the data line into bit 0 of the data register (address 2). The older bits move toward bit 7, so the first bit received ends up as the MSB.
- R3: With bus clocking enabled, the counter (status bits 3:0, address 1) advances on both clock edges. Its wrap from 15 to 0 sets the overflow flag (status bit 6). irq_ovf is high while that flag and the overflow enable (control bit 6) are both set.
- R4: If the counter is preloaded to 14, one full clock pulse (one rise and one fall) sets the overflow flag.
- R5: A data falling edge is checked one cycle after it is detected. If the clock is still high at that point, the start flag (status bit 7) is set. irq_start is high while that flag and the start enable (control bit 7) are both set.
- R6: A data rising edge is checked the same way. If the clock is still high, the stop flag (status bit 5) is set, and no interrupt is raised.
- R7: If the clock goes low within one cycle after a data edge, that edge is dropped, and neither flag is set.
- R8: Writing the status register clears each of bits 7..5 that is written as 1 and leaves the others unchanged. The same write loads bits 3:0 into the counter.
- R9: sda_pull_low is high only in two-wire mode, with the output enable (control bit 0) set and data bit 7 = 0. A write to the data register changes it on the next cycle.
- R10: In mode 3, scl_hold is high while the start flag or the overflow flag is set. In mode 2, scl_hold stays low.
- R11: In modes 0 and 1, bus activity leaves the counter, the data register and the flags unchanged, and the data line is not pulled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| sda_i | input | 1 | Data line level sensed from the bus |
| scl_i | input | 1 | Clock line level sensed from the bus |
| sda_pull_low | output | 1 | Drive the data line low (open drain) |
| scl_hold | output | 1 | Hold the clock line low |
| irq_start | output | 1 | Start interrupt request |
| irq_ovf | output | 1 | Counter overflow interrupt request |

## Verification
Three kinds of internal fault show up at the ports, each at a known time:
- A wrong counter moves the overflow flag, and the hold output in mode 3, to the wrong clock edge. The bench sees this within one byte.
- A shift fault corrupts the data byte read back after eight clock pulses. A sweep over all 256 byte values exposes any stuck or swapped bit.
- A wrong start/stop qualification gives a flag where none belongs, or a missing one. The glitch pattern shows this: the clock drops one cycle after the data edge, compared with two cycles after it. The result is visible in the status register a few cycles after the bus event.

// File: rtl/tw_shifter.sv
module tw_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sda_i,
  input  logic       scl_i,
  output logic       sda_pull_low,
  output logic       scl_hold,
  output logic       irq_start,
  output logic       irq_ovf
);

  logic [1:0] sda_sy, scl_sy;
  logic       sda_q, scl_q;
  logic       start_ie, ovf_ie, clk_en, out_en;
  logic [1:0] mode;
  logic       start_f, ovf_f, stop_f;
  logic [3:0] cnt;
  logic [7:0] dr;
  logic       pend_start, pend_stop;

  wire sda_s   = sda_sy[1];
  wire scl_s   = scl_sy[1];
  wire tw_on   = mode[1];
  wire clk_on  = tw_on & clk_en;
  wire scl_edg = clk_on & (scl_s ^ scl_q);
  wire scl_ris = clk_on & scl_s & ~scl_q;
  wire ctl_wr  = reg_wr & (reg_addr == 2'd0);
  wire st_wr   = reg_wr & (reg_addr == 2'd1);
  wire dr_wr   = reg_wr & (reg_addr == 2'd2);

  wire start_set = pend_start & scl_s;
  wire stop_set  = pend_stop & scl_s;
  wire ovf_set   = scl_edg & (cnt == 4'hF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_sy <= 2'b11;
      scl_sy <= 2'b11;
      sda_q  <= 1'b1;
      scl_q  <= 1'b1;
      pend_start <= 1'b0;
      pend_stop  <= 1'b0;
    end else begin
      sda_sy <= {sda_sy[0], sda_i};
      scl_sy <= {scl_sy[0], scl_i};
      sda_q  <= sda_s;
      scl_q  <= scl_s;
      pend_start <= tw_on & sda_q & ~sda_s;
      pend_stop  <= tw_on & ~sda_q & sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {start_ie, ovf_ie, mode, clk_en, out_en} <= '0;
      start_f <= 1'b0;
      ovf_f   <= 1'b0;
      stop_f  <= 1'b0;
      cnt     <= '0;
      dr      <= '0;
    end else begin
      if (ctl_wr) begin
        start_ie <= reg_wdata[7];
        ovf_ie   <= reg_wdata[6];
        mode     <= reg_wdata[5:4];
        clk_en   <= reg_wdata[3];
        out_en   <= reg_wdata[0];
      end
      start_f <= start_set | (start_f & ~(st_wr & reg_wdata[7]));
      ovf_f   <= ovf_set   | (ovf_f   & ~(st_wr & reg_wdata[6]));
      stop_f  <= stop_set  | (stop_f  & ~(st_wr & reg_wdata[5]));
      if (st_wr)        cnt <= reg_wdata[3:0];
      else if (scl_edg) cnt <= cnt + 4'd1;
      if (dr_wr)        dr <= reg_wdata;
      else if (scl_ris) dr <= {dr[6:0], sda_s};
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {start_ie, ovf_ie, mode, clk_en, 2'b00, out_en};
      2'd1:    reg_rdata = {start_f, ovf_f, stop_f, 1'b0, cnt};
      2'd2:    reg_rdata = dr;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign sda_pull_low = tw_on & out_en & ~dr[7];
  assign scl_hold     = (mode == 2'd3) & (start_f | ovf_f);
  assign irq_start    = start_f & start_ie;
  assign irq_ovf      = ovf_f & ovf_ie;

  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !st_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 4'd1));

  a_r3_ovf_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_wr && cnt == 4'hF) |=> (cnt == 4'hF || ovf_f));

  a_r5_start_needs_scl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_f) |-> $past(scl_s));

  a_r6_stop_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_f) |-> !$rose(irq_start));

  a_r8_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && reg_wdata[6] && !scl_edg) |=> !ovf_f);

  a_r11_idle_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (!tw_on && !st_wr && !dr_wr) |=> ($stable(cnt) && $stable(dr)));

endmodule

// File: tb/tb_tw_shifter.sv
module tb_tw_shifter;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic m_sda = 1, m_scl = 1;
  logic sda_pull_low, scl_hold, irq_start, irq_ovf;
  logic sda_i, scl_i;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign sda_i = m_sda & ~sda_pull_low;
  assign scl_i = m_scl & ~scl_hold;

  tw_shifter dut (.clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .sda_i, .scl_i, .sda_pull_low, .scl_hold, .irq_start, .irq_ovf);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic send_bit(logic b);
    m_sda = b; idle(4); m_scl = 1; idle(4); m_scl = 0; idle(4);
  endtask

  initial begin
    logic [7:0] v;
    idle(3); rst_n = 1; idle(2);
    // R1 reset state
    for (int a = 0; a < 3; a++) begin rd(a[1:0], v); chk("R1 reg", v, 8'h00); end
    chk("R1 outs", {4'h0, sda_pull_low, scl_hold, irq_start, irq_ovf}, 8'h00);

    // R5 start with enables
    wr(0, 8'hE8);
    idle(4); m_sda = 0; idle(6);
    rd(1, v); chk("R5 start flag", v, 8'h80);
    chk("R5 irq_start", {7'h0, irq_start}, 8'h01);
    m_scl = 0; idle(4);
    wr(1, 8'hF0);

    // R3 edge counting, R2 byte 0xA5
    m_sda = 1; idle(4); m_scl = 1; idle(4);
    rd(1, v); chk("R3 rise count", v, 8'h01);
    m_scl = 0; idle(4);
    rd(1, v); chk("R3 fall count", v, 8'h02);
    for (int i = 6; i >= 0; i--) send_bit(8'hA5 >> i);
    rd(1, v); chk("R3 overflow", v, 8'h40);
    chk("R3 irq_ovf", {7'h0, irq_ovf}, 8'h01);
    rd(2, v); chk("R2 byte A5", v, 8'hA5);

    // R2/R3 sweep over all byte values
    wr(0, 8'h28);
    chk("R3 irq_ovf masked", {7'h0, irq_ovf}, 8'h00);
    for (int b = 0; b < 256; b++) begin
      wr(1, 8'hF0);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      rd(2, v); chk("R2 sweep data", v, b[7:0]);
      rd(1, v); chk("R3 sweep status", v, 8'h40);
    end

    // R4 preload 14
    wr(1, 8'hFE);
    m_scl = 1; idle(4);
    rd(1, v); chk("R4 half pulse", v, 8'h0F);
    m_scl = 0; idle(4);
    rd(1, v); chk("R4 one bit ovf", v, 8'h40);

    // R8 write-one-to-clear
    wr(1, 8'h00); rd(1, v); chk("R8 zero keeps", v, 8'h40);
    wr(1, 8'h43); rd(1, v); chk("R8 clear+load", v, 8'h03);

    // R9 data pull
    wr(0, 8'h29);
    wr(2, 8'h00); chk("R9 pull low", {7'h0, sda_pull_low}, 8'h01);
    wr(2, 8'h80); chk("R9 release", {7'h0, sda_pull_low}, 8'h00);
    wr(0, 8'h28);
    wr(2, 8'h00); chk("R9 oe off", {7'h0, sda_pull_low}, 8'h00);

    // R6 stop
    wr(0, 8'hE8); wr(1, 8'hF0);
    m_sda = 0; idle(4); m_scl = 1; idle(4); m_sda = 1; idle(6);
    rd(1, v); chk("R6 stop flag", v, 8'h21);
    chk("R6 no irq", {6'h0, irq_start, irq_ovf}, 8'h00);

    // R7 glitch: clock falls one cycle after data edge
    wr(1, 8'hF0);
    @(negedge clk); m_sda = 0;
    @(negedge clk); m_scl = 0;
    idle(6);
    rd(1, v); chk("R7 dropped", v, 8'h01);
    m_sda = 1; idle(4); m_scl = 1; idle(4);
    wr(1, 8'hF0);
    @(negedge clk); m_sda = 0;
    @(negedge clk);
    @(negedge clk); m_scl = 0;
    idle(6);
    rd(1, v); chk("R7 two-cycle kept", v, 8'h81);

    // R10 hold mode
    wr(0, 8'h38); wr(1, 8'hF0);
    m_sda = 1; idle(4); m_scl = 1; idle(4);
    m_sda = 0; idle(6);
    chk("R10 hold on start", {7'h0, scl_hold}, 8'h01);
    chk("R10 scl pulled", {7'h0, scl_i}, 8'h00);
    m_scl = 0;
    wr(1, 8'hF0); idle(2);
    chk("R10 released", {7'h0, scl_hold}, 8'h00);
    wr(1, 8'hFE);
    m_scl = 1; idle(4); m_scl = 0; idle(4);
    chk("R10 hold on ovf", {7'h0, scl_hold}, 8'h01);
    wr(1, 8'h40); idle(2);
    chk("R10 ovf released", {7'h0, scl_hold}, 8'h00);
    wr(0, 8'h28); wr(1, 8'hFE);
    m_scl = 1; idle(4); m_scl = 0; idle(4);
    rd(1, v); chk("R10 mode2 ovf", v, 8'h40);
    chk("R10 mode2 no hold", {7'h0, scl_hold}, 8'h00);

    // R11 disabled mode
    wr(0, 8'h09); wr(2, 8'h00); wr(1, 8'hF0);
    chk("R11 no pull", {7'h0, sda_pull_low}, 8'h00);
    send_bit(1); send_bit(1);
    rd(2, v); chk("R11 data kept", v, 8'h00);
    rd(1, v); chk("R11 count kept", v, 8'h00);
    m_scl = 1; m_sda = 1; idle(4); m_sda = 0; idle(6); m_sda = 1; idle(6);
    rd(1, v); chk("R11 no flags", v, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule